// File: doc/BRIEF.md
# Autonegotiation Partner-Word Corruption Monitor

This block watches a PHY for a damaged link-partner ability word once autonegotiation has finished. Each time its tick input fires while it is idle, it walks a fixed series of register reads. It uses a management command port for the standard registers. It uses a separate bank-read request port for a hidden low-power-idle status register, and another sequencer serves that port. From the values it collects, it decides one of two outcomes. Either normal status decoding may go ahead, which it shows with a one-cycle pass pulse, or negotiation must be restarted.

When a restart is needed, the block rewrites the control register. The new value is the word it read at the start of the check, with isolation removed and both negotiation-enable and restart-negotiation forced on. A one-cycle restart pulse marks completion of that write. The check gives up early with a pass when autonegotiation is disabled, or when it has not yet completed. Both ports use a hold-until-acknowledge handshake: a request and its address and data stay fixed until the one-cycle acknowledge, and read data is valid alongside the acknowledge.

Top module: `aneg_lp_watch`

## Requirements
- R1: After reset, no management request, no bank request, no pass pulse and no restart pulse are active.
- R2: A tick while idle raises a management read of address 0 in the cycle after the tick.
- R3: If bit 12 of the address-0 word is zero, the check ends with a pass pulse and issues no further request.
- R4: If bit 5 of the address-1 word is zero, the check ends with a pass pulse after exactly the reads of addresses 0 and 1.
- R5: Past those two reads, the check reads bank 1, register 0x0C on the bank port, then management address 5, then management address 6, in that order. Bank port requests and management requests are never active together.
- R6: A zero in bit 12 of the bank-1 register 0x0C word marks corruption and leads to a restart.
- R7: Corruption is also marked when bit 0 of the address-6 word is one while bit 14 of the address-5 word is zero. With bit 0 of address 6 at zero, a clear bit 14 alone does not cause a restart.
- R8: On corruption, only after all four reads does the block issue one management write to address 0. The written data is the address-0 word with bit 10 cleared and bits 12 and 9 set. The restart output is high for exactly one cycle after the write is acknowledged, and no pass pulse occurs.
- R9: A check that finds no corruption ends with the pass output high for exactly one cycle.
- R10: A tick that arrives while a check is running is ignored: it neither starts a second check nor adds another outcome pulse.
- R11: A pending request holds its valid, direction and address unchanged until acknowledged, whatever the acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Starts a check when idle |
| mg_req_o | output | 1 | Management request valid |
| mg_wr_o | output | 1 | Management request is a write |
| mg_addr_o | output | 5 | Management register address |
| mg_wdata_o | output | 16 | Management write data |
| mg_ack_i | input | 1 | Management acknowledge, one cycle |
| mg_rdata_i | input | 16 | Management read data, valid with acknowledge |
| bk_req_o | output | 1 | Banked read request valid |
| bk_bank_o | output | 2 | Bank number |
| bk_reg_o | output | 5 | Register within bank |
| bk_ack_i | input | 1 | Banked read acknowledge, one cycle |
| bk_rdata_i | input | 16 | Banked read data, valid with acknowledge |
| pass_o | output | 1 | One-cycle pulse: status decoding may proceed |
| restart_o | output | 1 | One-cycle pulse: negotiation restart written |

## Verification
The hardest case to create from the ports is a tick that lands in the middle of a check. With prompt acknowledges, a check completes in a handful of cycles, so there is little time to hit it. The bench's responder therefore delays every acknowledge by several cycles, which stretches the check. The second tick is then placed while a read is still pending. The same slow responder records each request's address and direction when the request first appears and compares them at acknowledge time. This shows the hold behaviour under real latency.

// File: rtl/aneg_pkg.sv
package aneg_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 5;
  parameter int BANK_W = 2;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CTL  = 3'd1,
    S_STS  = 3'd2,
    S_LPI  = 3'd3,
    S_LPA  = 3'd4,
    S_EXP  = 3'd5,
    S_WR   = 3'd6
  } walk_t;

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LPA = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_EXP = ADDR_W'(6);
  localparam logic [BANK_W-1:0] B_LPI = BANK_W'(1);
  localparam logic [ADDR_W-1:0] R_LPI = ADDR_W'(12);

  localparam logic [DATA_W-1:0] M_ANEN    = DATA_W'(1) << 12;
  localparam logic [DATA_W-1:0] M_ISO     = DATA_W'(1) << 10;
  localparam logic [DATA_W-1:0] M_RENEG   = DATA_W'(1) << 9;
  localparam logic [DATA_W-1:0] M_ACOMP   = DATA_W'(1) << 5;
  localparam logic [DATA_W-1:0] M_LPI_OK  = DATA_W'(1) << 12;
  localparam logic [DATA_W-1:0] M_LP_ACK  = DATA_W'(1) << 14;
  localparam logic [DATA_W-1:0] M_LP_CAP  = DATA_W'(1) << 0;
endpackage

// File: rtl/aneg_verdict.sv
module aneg_verdict
  import aneg_pkg::*;
(
  input  logic [DATA_W-1:0] lpi_w,
  input  logic [DATA_W-1:0] lpa_w,
  input  logic [DATA_W-1:0] exp_w,
  input  logic [DATA_W-1:0] ctl_w,
  output logic              corrupt,
  output logic [DATA_W-1:0] rewrite_w
);
  logic lpi_bad;
  logic ack_bad;

  always_comb begin
    lpi_bad   = (lpi_w & M_LPI_OK) == '0;
    ack_bad   = ((exp_w & M_LP_CAP) != '0) && ((lpa_w & M_LP_ACK) == '0);
    corrupt   = lpi_bad | ack_bad;
    rewrite_w = (ctl_w & ~M_ISO) | M_ANEN | M_RENEG;
  end
endmodule

// File: rtl/aneg_issue.sv
module aneg_issue
  import aneg_pkg::*;
(
  input  walk_t             state,
  input  logic [DATA_W-1:0] rewrite_w,
  output logic              mg_req,
  output logic              mg_wr,
  output logic [ADDR_W-1:0] mg_addr,
  output logic [DATA_W-1:0] mg_wdata,
  output logic              bk_req,
  output logic [BANK_W-1:0] bk_bank,
  output logic [ADDR_W-1:0] bk_reg
);
  always_comb begin
    mg_req   = 1'b0;
    mg_wr    = 1'b0;
    mg_addr  = A_CTL;
    mg_wdata = '0;
    bk_req   = 1'b0;
    bk_bank  = B_LPI;
    bk_reg   = R_LPI;
    unique case (state)
      S_CTL: begin mg_req = 1'b1; mg_addr = A_CTL; end
      S_STS: begin mg_req = 1'b1; mg_addr = A_STS; end
      S_LPI: begin bk_req = 1'b1; end
      S_LPA: begin mg_req = 1'b1; mg_addr = A_LPA; end
      S_EXP: begin mg_req = 1'b1; mg_addr = A_EXP; end
      S_WR: begin
        mg_req   = 1'b1;
        mg_wr    = 1'b1;
        mg_addr  = A_CTL;
        mg_wdata = rewrite_w;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aneg_walk.sv
module aneg_walk
  import aneg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mg_ack,
  input  logic [DATA_W-1:0] mg_rdata,
  input  logic              bk_ack,
  input  logic [DATA_W-1:0] bk_rdata,
  input  logic              corrupt,
  output walk_t             state,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] lpi_q,
  output logic [DATA_W-1:0] lpa_q,
  output logic              pass,
  output logic              restart
);
  walk_t state_d;
  logic  pass_d, restart_d;
  logic  ctl_en, lpi_en, lpa_en;

  always_comb begin
    state_d   = state;
    pass_d    = 1'b0;
    restart_d = 1'b0;
    ctl_en    = 1'b0;
    lpi_en    = 1'b0;
    lpa_en    = 1'b0;
    unique case (state)
      S_IDLE: if (tick) state_d = S_CTL;
      S_CTL: if (mg_ack) begin
        ctl_en = 1'b1;
        if ((mg_rdata & M_ANEN) != '0) state_d = S_STS;
        else begin state_d = S_IDLE; pass_d = 1'b1; end
      end
      S_STS: if (mg_ack) begin
        if ((mg_rdata & M_ACOMP) != '0) state_d = S_LPI;
        else begin state_d = S_IDLE; pass_d = 1'b1; end
      end
      S_LPI: if (bk_ack) begin
        lpi_en  = 1'b1;
        state_d = S_LPA;
      end
      S_LPA: if (mg_ack) begin
        lpa_en  = 1'b1;
        state_d = S_EXP;
      end
      S_EXP: if (mg_ack) begin
        if (corrupt) state_d = S_WR;
        else begin state_d = S_IDLE; pass_d = 1'b1; end
      end
      S_WR: if (mg_ack) begin
        state_d   = S_IDLE;
        restart_d = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pass    <= 1'b0;
      restart <= 1'b0;
    end else begin
      state   <= state_d;
      pass    <= pass_d;
      restart <= restart_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      lpi_q <= '0;
      lpa_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= mg_rdata;
      if (lpi_en) lpi_q <= bk_rdata;
      if (lpa_en) lpa_q <= mg_rdata;
    end
  end
endmodule

// File: rtl/aneg_lp_watch.sv
module aneg_lp_watch
  import aneg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  output logic              mg_req_o,
  output logic              mg_wr_o,
  output logic [ADDR_W-1:0] mg_addr_o,
  output logic [DATA_W-1:0] mg_wdata_o,
  input  logic              mg_ack_i,
  input  logic [DATA_W-1:0] mg_rdata_i,
  output logic              bk_req_o,
  output logic [BANK_W-1:0] bk_bank_o,
  output logic [ADDR_W-1:0] bk_reg_o,
  input  logic              bk_ack_i,
  input  logic [DATA_W-1:0] bk_rdata_i,
  output logic              pass_o,
  output logic              restart_o
);
  walk_t             state;
  logic [DATA_W-1:0] ctl_q, lpi_q, lpa_q, rewrite_w;
  logic              corrupt;

  aneg_walk u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .mg_ack   (mg_ack_i),
    .mg_rdata (mg_rdata_i),
    .bk_ack   (bk_ack_i),
    .bk_rdata (bk_rdata_i),
    .corrupt  (corrupt),
    .state    (state),
    .ctl_q    (ctl_q),
    .lpi_q    (lpi_q),
    .lpa_q    (lpa_q),
    .pass     (pass_o),
    .restart  (restart_o)
  );

  aneg_verdict u_verdict (
    .lpi_w     (lpi_q),
    .lpa_w     (lpa_q),
    .exp_w     (mg_rdata_i),
    .ctl_w     (ctl_q),
    .corrupt   (corrupt),
    .rewrite_w (rewrite_w)
  );

  aneg_issue u_issue (
    .state     (state),
    .rewrite_w (rewrite_w),
    .mg_req    (mg_req_o),
    .mg_wr     (mg_wr_o),
    .mg_addr   (mg_addr_o),
    .mg_wdata  (mg_wdata_o),
    .bk_req    (bk_req_o),
    .bk_bank   (bk_bank_o),
    .bk_reg    (bk_reg_o)
  );
endmodule

// File: rtl/aneg_lp_watch_chk.sv
module aneg_lp_watch_chk
  import aneg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mg_req_o,
  input logic              mg_wr_o,
  input logic [ADDR_W-1:0] mg_addr_o,
  input logic [DATA_W-1:0] mg_wdata_o,
  input logic              mg_ack_i,
  input logic              bk_req_o,
  input logic              bk_ack_i,
  input logic              pass_o,
  input logic              restart_o
);
  a_r11_mg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_req_o && !mg_ack_i) |=> (mg_req_o && $stable(mg_addr_o) && $stable(mg_wr_o)));

  a_r11_bk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req_o && !bk_ack_i) |=> bk_req_o);

  a_r8_rewrite_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_req_o && mg_wr_o) |-> (mg_addr_o == '0 && mg_wdata_o[12] && mg_wdata_o[9] && !mg_wdata_o[10]));

  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);

  a_r9_pass_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |=> !pass_o);

  a_r8_no_pass_with_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && restart_o));

  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mg_req_o && bk_req_o));
endmodule

bind aneg_lp_watch aneg_lp_watch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mg_req_o   (mg_req_o),
  .mg_wr_o    (mg_wr_o),
  .mg_addr_o  (mg_addr_o),
  .mg_wdata_o (mg_wdata_o),
  .mg_ack_i   (mg_ack_i),
  .bk_req_o   (bk_req_o),
  .bk_ack_i   (bk_ack_i),
  .pass_o     (pass_o),
  .restart_o  (restart_o)
);

// File: tb/tb_aneg_lp_watch.sv
`timescale 1ns/1ps
module tb_aneg_lp_watch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        mg_req_o, mg_wr_o, bk_req_o, pass_o, restart_o;
  logic [4:0]  mg_addr_o, bk_reg_o;
  logic [15:0] mg_wdata_o;
  logic [1:0]  bk_bank_o;
  logic        mg_ack_i = 1'b0, bk_ack_i = 1'b0;
  logic [15:0] mg_rdata_i = '0, bk_rdata_i = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // Responder register image
  logic [15:0] v_ctl, v_sts, v_lpi, v_lpa, v_exp;
  int resp_wait = 0;
  int waited = 0;
  // Transaction log: kind 0 = read, 1 = write, 2 = bank read (addr = bank*32+reg)
  int lg_n = 0;
  int lg_kind [0:15];
  int lg_addr [0:15];
  logic [15:0] lg_wd [0:15];
  int hold_err = 0;
  int pass_cnt = 0, rst_cnt = 0, pass_run = 0, rst_run = 0, pass_max = 0, rst_max = 0;
  logic [5:0] first_addr;
  logic first_wr;

  always #2 clk = ~clk;

  aneg_lp_watch dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .mg_req_o(mg_req_o), .mg_wr_o(mg_wr_o), .mg_addr_o(mg_addr_o), .mg_wdata_o(mg_wdata_o),
    .mg_ack_i(mg_ack_i), .mg_rdata_i(mg_rdata_i),
    .bk_req_o(bk_req_o), .bk_bank_o(bk_bank_o), .bk_reg_o(bk_reg_o),
    .bk_ack_i(bk_ack_i), .bk_rdata_i(bk_rdata_i),
    .pass_o(pass_o), .restart_o(restart_o)
  );

  function automatic logic [15:0] rd_val(input logic [4:0] a);
    case (a)
      5'd0: rd_val = v_ctl;
      5'd1: rd_val = v_sts;
      5'd5: rd_val = v_lpa;
      5'd6: rd_val = v_exp;
      default: rd_val = 16'hDEAD;
    endcase
  endfunction

  // Responder and pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pass_o) begin pass_cnt++; pass_run++; end else pass_run = 0;
      if (restart_o) begin rst_cnt++; rst_run++; end else rst_run = 0;
      if (pass_run > pass_max) pass_max = pass_run;
      if (rst_run > rst_max) rst_max = rst_run;
      if (mg_ack_i || bk_ack_i) begin
        mg_ack_i = 1'b0; bk_ack_i = 1'b0; waited = 0;
      end else if (mg_req_o || bk_req_o) begin
        if (waited == 0) begin
          first_addr = mg_req_o ? {1'b0, mg_addr_o} : {bk_bank_o[0], bk_reg_o};
          first_wr   = mg_req_o & mg_wr_o;
        end else begin
          if ((mg_req_o ? {1'b0, mg_addr_o} : {bk_bank_o[0], bk_reg_o}) != first_addr ||
              (mg_req_o & mg_wr_o) != first_wr) hold_err++;
        end
        if (waited >= resp_wait) begin
          if (lg_n < 16) begin
            lg_kind[lg_n] = bk_req_o ? 2 : (mg_wr_o ? 1 : 0);
            lg_addr[lg_n] = bk_req_o ? (int'(bk_bank_o) * 32 + int'(bk_reg_o)) : int'(mg_addr_o);
            lg_wd[lg_n]   = mg_wdata_o;
          end
          lg_n++;
          if (bk_req_o) begin bk_ack_i = 1'b1; bk_rdata_i = v_lpi; end
          else begin
            mg_ack_i = 1'b1;
            mg_rdata_i = mg_wr_o ? 16'h0 : rd_val(mg_addr_o);
            if (mg_wr_o) v_ctl = mg_wdata_o;
          end
        end else waited++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  task automatic arm(input logic [15:0] c, s, l, p, e);
    @(negedge clk);
    v_ctl = c; v_sts = s; v_lpi = l; v_lpa = p; v_exp = e;
    lg_n = 0; pass_cnt = 0; rst_cnt = 0; pass_max = 0; rst_max = 0; hold_err = 0;
  endtask

  task automatic fire();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic check_full_reads(input string req);
    chk(req, lg_kind[0] * 100 + lg_addr[0], 0, "read 0");
    chk(req, lg_kind[1] * 100 + lg_addr[1], 1, "read 1");
    chk(req, lg_kind[2] * 100 + lg_addr[2], 244, "bank 1 reg 0x0C");
    chk(req, lg_kind[3] * 100 + lg_addr[3], 5, "read 5");
    chk(req, lg_kind[4] * 100 + lg_addr[4], 6, "read 6");
  endtask

  task automatic t_reset();
    chk("R1", {mg_req_o, bk_req_o, pass_o, restart_o}, 0, "outputs at reset");
  endtask

  task automatic t_an_off();
    arm(16'h0000, 16'h0020, 16'h1000, 16'h4000, 16'h0001);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk("R2", {mg_req_o, mg_wr_o, mg_addr_o}, 10'b1000000, "read 0 after tick");
    settle();
    chk("R3", lg_n, 1, "request count");
    chk("R3", pass_cnt, 1, "pass pulses");
    chk("R3", rst_cnt, 0, "restart pulses");
  endtask

  task automatic t_not_done();
    arm(16'h1000, 16'h0000, 16'h1000, 16'h4000, 16'h0001);
    fire(); settle();
    chk("R4", lg_n, 2, "request count");
    chk("R4", lg_addr[1], 1, "second address");
    chk("R4", pass_cnt, 1, "pass pulses");
  endtask

  task automatic t_clean();
    arm(16'h1000, 16'h0020, 16'h1000, 16'h4000, 16'h0001);
    fire(); settle();
    chk("R5", lg_n, 5, "request count");
    check_full_reads("R5");
    chk("R9", pass_cnt, 1, "pass pulses");
    chk("R9", pass_max, 1, "pass width");
    chk("R9", rst_cnt, 0, "restart pulses");
  endtask

  task automatic t_lpi_bad();
    arm(16'h1400, 16'h0020, 16'h0000, 16'h4000, 16'h0001);
    fire(); settle();
    chk("R6", lg_n, 6, "request count");
    check_full_reads("R8");
    chk("R8", lg_kind[5] * 100 + lg_addr[5], 100, "write to 0");
    chk("R8", int'(lg_wd[5]), 16'h1200, "rewrite data");
    chk("R6", rst_cnt, 1, "restart pulses");
    chk("R8", rst_max, 1, "restart width");
    chk("R8", pass_cnt, 0, "no pass");
  endtask

  task automatic t_ack_missing();
    arm(16'h30FF, 16'h0020, 16'h1000, 16'h0000, 16'h0001);
    fire(); settle();
    chk("R7", lg_n, 6, "request count");
    chk("R7", int'(lg_wd[5]), 16'h32FF, "rewrite data");
    chk("R7", rst_cnt, 1, "restart pulses");
    chk("R7", pass_cnt, 0, "no pass");
  endtask

  task automatic t_not_capable();
    arm(16'h1000, 16'h0020, 16'h1000, 16'h0000, 16'h0000);
    fire(); settle();
    chk("R7", lg_n, 5, "no write when partner not capable");
    chk("R7", pass_cnt, 1, "pass pulses");
    chk("R7", rst_cnt, 0, "restart pulses");
  endtask

  task automatic t_busy_tick();
    arm(16'h1000, 16'h0020, 16'h1000, 16'h4000, 16'h0001);
    resp_wait = 4;
    fire();
    repeat (6) @(negedge clk);
    fire();
    repeat (12) @(negedge clk);
    fire();
    repeat (120) @(negedge clk);
    chk("R10", lg_n, 5, "request count with mid-check ticks");
    chk("R10", pass_cnt, 1, "pass pulses");
    check_full_reads("R10");
    chk("R11", hold_err, 0, "request changed while pending");
    resp_wait = 0;
  endtask

  task automatic t_slow_restart();
    arm(16'h0400, 16'h0020, 16'h0000, 16'h4000, 16'h0001);
    resp_wait = 3;
    v_ctl = 16'h1400;
    fire();
    repeat (120) @(negedge clk);
    chk("R11", hold_err, 0, "request changed while pending");
    chk("R11", int'(lg_wd[5]), 16'h1200, "rewrite data under latency");
    chk("R11", rst_cnt, 1, "restart pulses");
    resp_wait = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_an_off();
    t_not_done();
    t_clean();
    t_lpi_bad();
    t_ack_missing();
    t_not_capable();
    t_busy_tick();
    t_slow_restart();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule